// File: doc/BRIEF.md
# Edge-Qualified Pin Event Extractor

A GPIO bank that has two channels raises only one status pulse per channel. The pulse says that some input in that channel changed. It does not say which pin changed or in which direction. This block turns those coarse pulses into separate events for individual pins. For every pin it keeps an enable bit and two trigger-select bits, one for rising edges and one for falling edges. For every pin it also keeps a snapshot of the channel data taken at the last evaluation. When a channel's status pulse arrives, the block samples that channel's live data and compares it with the snapshot to find which pins moved and in which direction. It then filters the result with the per-pin selects and replaces the snapshot with the sampled data.

The qualified events leave one at a time as global pin numbers on a valid/ready output. The events of one channel are emitted in ascending bit order. Channel 0 always has priority over channel 1. Channel 1 pins are numbered after all channel 0 pins. Configuration uses a single-cycle command port. The block drives a per-channel interrupt-enable output back to the bank, and a one-cycle clear strobe when a channel is first armed.

Top module: `pin_edge_extract`

## Requirements
- R1: A rising event is produced for a pin only when, at evaluation, its sampled data is 1, its snapshot is 0, its enable bit is set and its rising select is set.
- R2: A falling event is produced for a pin only when, at evaluation, its sampled data is 0, its snapshot is 1, its enable bit is set and its falling select is set.
- R3: An evaluation replaces the snapshot of every pin of the evaluated channel with the sampled data, including pins that are disabled. A later evaluation of unchanged data therefore yields no event for those pins.
- R4: Command opcodes are: 00 set trigger, 01 enable pin, 10 disable pin, 11 reserved. The accepted trigger codes are 001 (rising only), 010 (falling only) and 011 (both edges). Any other trigger code, including a level-type code, is rejected. The reserved opcode and a pin number of the total width or above are also rejected. A rejected command pulses cfg_err for one cycle and leaves all configuration unchanged.
- R5: Enabling a pin in a channel that has no enabled pin does three things. It pulses that channel's stat_clr bit for one cycle, drops any status pending in the block for that channel, and captures the live data into the channel snapshot. ch_ien for that channel rises in the same cycle. Enabling a pin in an already armed channel captures nothing.
- R6: ch_ien for a channel falls when the last enabled pin of that channel is disabled. It stays high while any pin of the channel is still enabled.
- R7: Pending channels are evaluated channel 0 first. The event pin number is the bit index for channel 0, and the bit index plus CH0_W for channel 1.
- R8: The events of one evaluation are emitted in ascending pin order. A pin that qualifies emits exactly one event, whether it qualified as rising or as falling.
- R9: While ev_valid is high and ev_ready is low, ev_valid stays high and ev_pin holds its value.
- R10: A status pulse that arrives while events are still draining is held pending. Its channel is evaluated with the data present after the current batch has fully drained.
- R11: A status pulse on a channel whose ch_ien is low is ignored.
- R12: After reset, all masks and snapshots are zero, ch_ien, stat_clr and cfg_err are low, and ev_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration command strobe |
| cfg_op | input | 2 | Command opcode (R4) |
| cfg_pin | input | PW | Global pin number addressed by the command |
| cfg_trig | input | 3 | Trigger code for the set-trigger command |
| cfg_err | output | 1 | One-cycle pulse on a rejected command |
| ch0_data | input | CH0_W | Live data of channel 0 |
| ch1_data | input | CH1_W | Live data of channel 1 |
| ch_stat | input | 2 | Per-channel change status pulse |
| ch_ien | output | 2 | Per-channel interrupt enable to the bank |
| stat_clr | output | 2 | Per-channel status clear strobe |
| ev_valid | output | 1 | Event available |
| ev_ready | input | 1 | Event consumer ready |
| ev_pin | output | PW | Global pin number of the event |

## Verification
Directed cases cover four kinds of change: one pin per trigger type moving in one channel, a simultaneous change in both channels, a pulse that arrives in the middle of a draining batch with new data, and a toggle on a disabled pin that is enabled later. These cases separate the rising path from the falling path, the channel priority from the pin order, pending status from status that was lost, and a stale snapshot from a refreshed one. Rejected commands are each followed by a data change that would fire only under a corrupted configuration. Seeded random rounds then mix commands, data and pulses under a stalling ready signal, so that the hold-while-stalled rule is exercised on many event sequences.

// File: rtl/pin_edge_pkg.sv
package pin_edge_pkg;

    typedef enum logic [1:0] {
        OP_TRIG = 2'b00,
        OP_EN   = 2'b01,
        OP_DIS  = 2'b10,
        OP_RSVD = 2'b11
    } cfg_op_e;

    localparam logic [2:0] TRIG_RISE = 3'b001;
    localparam logic [2:0] TRIG_FALL = 3'b010;
    localparam logic [2:0] TRIG_BOTH = 3'b011;

endpackage

// File: rtl/pin_edge_qual.sv
module pin_edge_qual #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] snap,
    input  logic [W-1:0] en,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    output logic [W-1:0] ev
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic up_w, dn_w;
        assign up_w  = cur[i] & ~snap[i] & rise[i];
        assign dn_w  = ~cur[i] & snap[i] & fall[i];
        assign ev[i] = en[i] & (up_w | dn_w);
    end
endmodule

// File: rtl/pin_lsb_pick.sv
module pin_lsb_pick #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/pin_edge_extract.sv
module pin_edge_extract
    import pin_edge_pkg::*;
#(
    parameter int CH0_W = 8,
    parameter int CH1_W = 6,
    localparam int TOTAL = CH0_W + CH1_W,
    localparam int PW = $clog2(TOTAL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  logic [1:0]       cfg_op,
    input  logic [PW-1:0]    cfg_pin,
    input  logic [2:0]       cfg_trig,
    output logic             cfg_err,
    input  logic [CH0_W-1:0] ch0_data,
    input  logic [CH1_W-1:0] ch1_data,
    input  logic [1:0]       ch_stat,
    output logic [1:0]       ch_ien,
    output logic [1:0]       stat_clr,
    output logic             ev_valid,
    input  logic             ev_ready,
    output logic [PW-1:0]    ev_pin
);
    localparam logic [TOTAL-1:0] M0 = {{CH1_W{1'b0}}, {CH0_W{1'b1}}};
    localparam logic [TOTAL-1:0] M1 = ~M0;

    typedef struct packed {
        logic [TOTAL-1:0] en;
        logic [TOTAL-1:0] rise;
        logic [TOTAL-1:0] fall;
        logic [TOTAL-1:0] snap;
        logic [TOTAL-1:0] evq;
        logic [1:0]       pend;
        logic [1:0]       ien;
        logic [1:0]       sclr;
        logic             err;
    } st_t;

    st_t q, d;

    logic [TOTAL-1:0] data_w, evt_w, pin_bit_w, pin_m_w, eval_m_w;
    logic             pin_ok_w, pin_ch_w, eval_go_w, eval_ch_w;

    assign data_w = {ch1_data, ch0_data};

    pin_edge_qual #(.W(TOTAL)) u_qual (
        .cur (data_w),
        .snap(q.snap),
        .en  (q.en),
        .rise(q.rise),
        .fall(q.fall),
        .ev  (evt_w)
    );

    pin_lsb_pick #(.W(TOTAL), .IW(PW)) u_pick (
        .vec(q.evq),
        .idx(ev_pin)
    );

    assign ev_valid = |q.evq;
    assign ch_ien   = q.ien;
    assign stat_clr = q.sclr;
    assign cfg_err  = q.err;

    always_comb begin
        pin_ok_w  = 32'(cfg_pin) < TOTAL;
        pin_ch_w  = 32'(cfg_pin) >= CH0_W;
        pin_bit_w = {{(TOTAL-1){1'b0}}, 1'b1} << cfg_pin;
        pin_m_w   = pin_ch_w ? M1 : M0;
        eval_go_w = (q.evq == '0) && (q.pend != 2'b00);
        eval_ch_w = ~q.pend[0];
        eval_m_w  = eval_ch_w ? M1 : M0;

        d      = q;
        d.sclr = 2'b00;
        d.err  = 1'b0;

        // consume the lowest pending event
        if (ev_valid && ev_ready) begin
            d.evq = q.evq & (q.evq - 1'b1);
        end

        // evaluate one pending channel once the queue is empty
        if (eval_go_w) begin
            d.evq  = evt_w & eval_m_w;
            d.snap = (q.snap & ~eval_m_w) | (data_w & eval_m_w);
            d.pend[eval_ch_w] = 1'b0;
        end

        d.pend = d.pend | (ch_stat & q.ien);

        if (cfg_valid) begin
            if (!pin_ok_w) begin
                d.err = 1'b1;
            end else begin
                case (cfg_op_e'(cfg_op))
                    OP_TRIG: begin
                        case (cfg_trig)
                            TRIG_RISE: begin
                                d.rise = q.rise | pin_bit_w;
                                d.fall = q.fall & ~pin_bit_w;
                            end
                            TRIG_FALL: begin
                                d.rise = q.rise & ~pin_bit_w;
                                d.fall = q.fall | pin_bit_w;
                            end
                            TRIG_BOTH: begin
                                d.rise = q.rise | pin_bit_w;
                                d.fall = q.fall | pin_bit_w;
                            end
                            default: d.err = 1'b1;
                        endcase
                    end
                    OP_EN: begin
                        if (!q.ien[pin_ch_w]) begin
                            d.sclr[pin_ch_w] = 1'b1;
                            d.pend[pin_ch_w] = 1'b0;
                            d.snap = (d.snap & ~pin_m_w) | (data_w & pin_m_w);
                            d.ien[pin_ch_w]  = 1'b1;
                        end
                        d.en = q.en | pin_bit_w;
                    end
                    OP_DIS: begin
                        d.en = q.en & ~pin_bit_w;
                        if ((q.en & ~pin_bit_w & pin_m_w) == '0) begin
                            d.ien[pin_ch_w] = 1'b0;
                        end
                    end
                    default: d.err = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_EV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && !ev_ready |=> ev_valid && $stable(ev_pin)); // R9
    AST_PIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> 32'(ev_pin) < TOTAL); // R7
    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        !((|(q.evq & M0)) && (|(q.evq & M1)))); // R7
    AST_IEN0_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        ch_ien[0] == |(q.en & M0)); // R6
    AST_IEN1_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        ch_ien[1] == |(q.en & M1)); // R6
    AST_CLR0_ON_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr[0] |-> $rose(ch_ien[0])); // R5
    AST_CLR1_ON_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr[1] |-> $rose(ch_ien[1])); // R5
    AST_ERR_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(cfg_valid)); // R4
    AST_IGNORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ch_stat[1] && !ch_ien[1] && q.pend[1] == 1'b0 && !(cfg_valid && cfg_op == 2'b01)
        |=> !q.pend[1]); // R11
endmodule

// File: tb/sim_pin_edge_extract.sv
module sim_pin_edge_extract;
    localparam int W0 = 8;
    localparam int W1 = 6;
    localparam int T  = W0 + W1;
    localparam int PW = $clog2(T);
    localparam logic [T-1:0] M0 = {{W1{1'b0}}, {W0{1'b1}}};
    localparam logic [T-1:0] M1 = ~M0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_valid = 1'b0;
    logic [1:0]    cfg_op = '0;
    logic [PW-1:0] cfg_pin = '0;
    logic [2:0]    cfg_trig = '0;
    logic          cfg_err;
    logic [W0-1:0] ch0_data = '0;
    logic [W1-1:0] ch1_data = '0;
    logic [1:0]    ch_stat = '0;
    logic [1:0]    ch_ien;
    logic [1:0]    stat_clr;
    logic          ev_valid;
    logic          ev_ready = 1'b0;
    logic [PW-1:0] ev_pin;

    int nchecks = 0;
    int nerr = 0;
    bit done = 0;

    logic [T-1:0] m_en = '0, m_rise = '0, m_fall = '0, m_snap = '0;
    logic [1:0]   m_ien = '0;
    int exp_q[$];

    always #10 clk = ~clk;

    pin_edge_extract #(.CH0_W(W0), .CH1_W(W1)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_op(cfg_op),
        .cfg_pin(cfg_pin), .cfg_trig(cfg_trig), .cfg_err(cfg_err),
        .ch0_data(ch0_data), .ch1_data(ch1_data), .ch_stat(ch_stat),
        .ch_ien(ch_ien), .stat_clr(stat_clr), .ev_valid(ev_valid),
        .ev_ready(ev_ready), .ev_pin(ev_pin)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [T-1:0] chmask(int c);
        return (c == 0) ? M0 : M1;
    endfunction

    // expected events of one channel evaluation, ascending, snapshot refreshed
    task automatic push_events(int c);
        logic [T-1:0] cur, m, ev;
        cur = {ch1_data, ch0_data};
        m   = chmask(c);
        ev  = m_en & m & ((cur & ~m_snap & m_rise) | (~cur & m_snap & m_fall));
        for (int i = 0; i < T; i++) if (ev[i]) exp_q.push_back(i);
        m_snap = (m_snap & ~m) | (cur & m);
    endtask

    task automatic do_cfg(logic [1:0] op, int pin, logic [2:0] trig, string tag);
        bit bad;
        int c;
        logic [T-1:0] b;
        logic [1:0] exp_clr;
        bad = (pin >= T) || (op == 2'b11) ||
              (op == 2'b00 && !(trig == 3'b001 || trig == 3'b010 || trig == 3'b011));
        c = (pin >= W0) ? 1 : 0;
        b = (pin < T) ? ({{(T-1){1'b0}}, 1'b1} << pin) : '0;
        exp_clr = '0;
        @(negedge clk);
        cfg_valid = 1'b1; cfg_op = op; cfg_pin = PW'(pin); cfg_trig = trig;
        @(negedge clk);
        cfg_valid = 1'b0;
        if (!bad) begin
            case (op)
                2'b00: begin
                    m_rise = trig[0] ? (m_rise | b) : (m_rise & ~b);
                    m_fall = trig[1] ? (m_fall | b) : (m_fall & ~b);
                end
                2'b01: begin
                    if (!m_ien[c]) begin
                        exp_clr[c] = 1'b1;
                        m_snap = (m_snap & ~chmask(c)) | ({ch1_data, ch0_data} & chmask(c));
                        m_ien[c] = 1'b1;
                    end
                    m_en = m_en | b;
                end
                default: begin
                    m_en = m_en & ~b;
                    if ((m_en & chmask(c)) == '0) m_ien[c] = 1'b0;
                end
            endcase
        end
        chk(cfg_err == bad, {tag, " R4 cfg_err"}, int'(cfg_err), int'(bad));
        chk(stat_clr == exp_clr, {tag, " R5 stat_clr"}, int'(stat_clr), int'(exp_clr));
        chk(ch_ien == m_ien, {tag, " R5/R6 ch_ien"}, int'(ch_ien), int'(m_ien));
    endtask

    task automatic pulse(logic [1:0] m);
        @(negedge clk);
        ch_stat = m;
        for (int c = 0; c < 2; c++) if (m[c] && m_ien[c]) push_events(c);
        @(negedge clk);
        ch_stat = 2'b00;
    endtask

    // mode 0: always ready, 1: random ready, 2: stalled for 4 cycles then ready
    task automatic drain(int mode, int mid_at, logic [W0-1:0] mid_data, string tag);
        bit pv, pr, r;
        logic [PW-1:0] pp;
        int idle, e;
        pv = 0; pr = 0; pp = '0; idle = 0;
        for (int cyc = 0; cyc < 600; cyc++) begin
            @(negedge clk);
            if (cyc == mid_at) begin
                ch0_data = mid_data;
                ch_stat = 2'b01;
                if (m_ien[0]) push_events(0);
            end else if (cyc == mid_at + 1) begin
                ch_stat = 2'b00;
            end
            if (pv && !pr)
                chk(ev_valid && ev_pin == pp, "R9 hold", int'(ev_pin), int'(pp));
            case (mode)
                0: r = 1'b1;
                1: r = ($urandom % 3) != 0;
                default: r = (cyc >= 4);
            endcase
            ev_ready = r;
            if (ev_valid && r) begin
                e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
                chk(int'(ev_pin) == e, {tag, " event pin"}, int'(ev_pin), e);
            end
            idle = (!ev_valid && exp_q.size() == 0) ? idle + 1 : 0;
            pv = ev_valid; pr = r; pp = ev_pin;
            if (idle >= 4 && cyc > mid_at + 2) break;
        end
        @(negedge clk);
        ev_ready = 1'b0;
        chk(exp_q.size() == 0, {tag, " missing events"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(!ev_valid, "R12 ev_valid", int'(ev_valid), 0);
        chk(ch_ien == 2'b00, "R12 ch_ien", int'(ch_ien), 0);
        chk(stat_clr == 2'b00 && !cfg_err, "R12 strobes", int'({stat_clr, cfg_err}), 0);

        // R1 R2 R8: one pin per trigger type in channel 0
        ch0_data = 8'b0000_0100;
        do_cfg(2'b00, 1, 3'b001, "R1");
        do_cfg(2'b00, 2, 3'b010, "R2");
        do_cfg(2'b00, 3, 3'b011, "R8");
        do_cfg(2'b01, 1, 3'b000, "R5 arm");
        do_cfg(2'b01, 2, 3'b000, "R5 noarm");
        do_cfg(2'b01, 3, 3'b000, "R5 noarm");
        ch0_data = 8'b0000_1010;
        pulse(2'b01);
        drain(0, -10, '0, "R1/R2/R8 mixed edges");
        ch0_data = 8'b0000_0100;
        pulse(2'b01);
        drain(1, -10, '0, "R1/R2/R8 reversed");

        // R4 rejected commands leave config unchanged
        do_cfg(2'b00, 1, 3'b100, "R4 level code");
        do_cfg(2'b00, 1, 3'b000, "R4 zero code");
        do_cfg(2'b11, 1, 3'b001, "R4 reserved op");
        do_cfg(2'b01, 15, 3'b000, "R4 pin range");
        do_cfg(2'b00, 14, 3'b001, "R4 pin range");
        ch0_data = 8'b0000_0110;
        pulse(2'b01);
        drain(0, -10, '0, "R4 config intact");
        ch0_data = 8'b0000_0100;
        pulse(2'b01);
        drain(0, -10, '0, "R4 config intact");

        // R11 channel 1 not armed
        ch1_data = 6'b11_1111;
        pulse(2'b10);
        drain(0, -10, '0, "R11 ignored");

        // R7 both channels at once
        do_cfg(2'b00, 8, 3'b011, "R7");
        do_cfg(2'b00, 13, 3'b011, "R7");
        do_cfg(2'b01, 8, 3'b000, "R5 arm ch1");
        do_cfg(2'b01, 13, 3'b000, "R7");
        ch1_data = 6'b01_1110;
        ch0_data = 8'b0000_1010;
        pulse(2'b11);
        drain(1, -10, '0, "R7 channel order");

        // R10 pulse during drain, R9 stall
        ch1_data = 6'b10_0001;
        pulse(2'b10);
        drain(2, 1, 8'b0000_0100, "R10 pending");

        // R3 snapshot refresh covers disabled pins
        ch0_data = 8'b0010_0100;
        pulse(2'b01);
        drain(0, -10, '0, "R3 disabled toggle");
        do_cfg(2'b00, 5, 3'b001, "R3");
        do_cfg(2'b01, 5, 3'b000, "R3");
        pulse(2'b01);
        drain(0, -10, '0, "R3 no stale event");

        // R6 last disable
        do_cfg(2'b10, 8, 3'b000, "R6 one left");
        do_cfg(2'b10, 13, 3'b000, "R6 last");
        do_cfg(2'b10, 13, 3'b000, "R6 repeat");

        // random rounds
        for (int it = 0; it < 40; it++) begin
            for (int k = 0; k < 3; k++) begin
                int op, pin, tr;
                op  = $urandom % 4;
                if (op == 3 && ($urandom % 2)) op = 1;
                pin = $urandom % 16;
                tr  = $urandom % 8;
                do_cfg(op[1:0], pin, tr[2:0], "R1/R2 rnd");
            end
            ch0_data = W0'($urandom);
            ch1_data = W1'($urandom);
            pulse(2'(1 + $urandom % 3));
            drain(1, -10, '0, "R8 rnd");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            nchecks++;
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    end
endmodule